// File: doc/BRIEF.md
# Weighted-Fair-Queue Credit Gate

This block sits beside a transmit arbiter and decides, cycle by cycle, which of nine requesting clients may take part in arbitration. Clients are numbered 0 for management, 1 for debug traffic of the local port, 2 for debug traffic of the peer port, and 3 to 8 for traffic classes 0 to 5. Any client may be marked as weight-controlled. A weight-controlled client is tied, through a programmable nibble map, to one of nine signed byte-credit counters. It is held back whenever that counter is below zero.

Each grant reported by the arbiter takes the packet length away from the counter of the granted client. When every weight-controlled client that is requesting is held back, all nine counters gain their byte weight in the same cycle. Each result is limited to the counter's own ceiling. The map is checked continuously: a shared counter or an out-of-range entry raises a configuration error.

Top module: `ets_credit_unit`

## Requirements
- R1: After reset every counter holds zero, the map holds 0x543210876 (client c uses bits [4c+3:4c]; clients 0,1,2 use counters 6,7,8; clients 3..8 use counters 0..5), `cfg_err_o` is low, and every requesting client is eligible.
- R2: `eligible_o` is never set for a client that is not requesting. A requesting client whose `wfq_i` bit is 0 is always eligible, and its map entry, valid or not, takes no part in the configuration check.
- R3: A grant to a weight-controlled client with a valid entry subtracts `grant_len_i` from the mapped counter at the next edge. The client is ineligible while that counter is negative, and a counter of exactly zero does not block.
- R4: A grant to a client whose `wfq_i` bit is 0, or with an identifier above 8, changes no counter.
- R5: When at least one weight-controlled client is requesting and all such requesting clients are blocked, every counter adds its 32-bit weight at the next edge.
- R6: A refill never takes a counter above its 32-bit ceiling. A sum above the ceiling is replaced by the ceiling.
- R7: No refill happens while any requesting weight-controlled client is eligible.
- R8: A pulse on `map_wr_i` loads `map_wdata_i`, which shows on `map_o` after the edge. Without the pulse the map holds its value.
- R9: `cfg_err_o` is high while two weight-controlled clients map to the same counter.
- R10: A weight-controlled client whose entry exceeds 8 raises `cfg_err_o`, is never eligible, and its grants are ignored.
- R11: When a refill and a debit reach one counter in the same cycle, the weight is added and limited to the ceiling first, and the length is subtracted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 9 | Per-client request |
| wfq_i | input | 9 | Per-client weight-control enable |
| map_wr_i | input | 1 | Load strobe for the client-to-counter map |
| map_wdata_i | input | 36 | New map, one nibble per client |
| weight_i | input | 288 | Byte weight per counter, 32 bits each, counter k at [32k+31:32k] |
| bound_i | input | 288 | Ceiling per counter, 32 bits each |
| grant_vld_i | input | 1 | Grant event valid |
| grant_id_i | input | 4 | Granted client identifier |
| grant_len_i | input | 16 | Granted packet length in bytes |
| eligible_o | output | 9 | Clients allowed to compete |
| map_o | output | 36 | Map currently in force |
| cfg_err_o | output | 1 | Map conflict or out-of-range entry |

## Verification
A counter that holds a wrong value shows at the ports only as a change of sign. The bench therefore drives debits that land exactly on -1 or 0, so that an error of one byte flips a bit of `eligible_o` on the next cycle. A wrong ceiling, or a wrong order of refill and debit, is made visible by a debit one byte larger than the ceiling allows. A damaged map appears at once on `map_o` and, through the duplicate and range checks, on `cfg_err_o` in the same cycle.

// File: rtl/ets_credit_pkg.sv
package ets_credit_pkg;
  localparam int NUM_CLIENTS = 9;
  localparam int NUM_COUNTERS = 9;
  localparam int SEL_BITS = 4;
  localparam int AMT_BITS = 32;
  localparam int LEN_BITS = 16;
  localparam logic [NUM_CLIENTS*SEL_BITS-1:0] MAP_DEFAULT = 36'h543210876;
endpackage

// File: rtl/ets_credit_map.sv
module ets_credit_map #(
  parameter int N_CLI = 9,
  parameter int N_CRD = 9,
  parameter int SEL_W = 4,
  parameter logic [N_CLI*SEL_W-1:0] MAP_INIT = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [N_CLI*SEL_W-1:0] wdata_i,
  input  logic [N_CLI-1:0]       wfq_i,
  output logic [N_CLI*SEL_W-1:0] map_o,
  output logic [N_CLI-1:0]       bad_o,
  output logic                   cfg_err_o
);
  localparam int SLOTS = 1 << SEL_W;

  logic [N_CLI*SEL_W-1:0] map_q, map_d;
  logic [SLOTS-1:0]       used;
  logic [SEL_W-1:0]       sel;
  logic                   clash;

  always_comb begin
    map_d = map_q;
    if (wr_i) map_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= MAP_INIT;
    else if (wr_i) map_q <= map_d;
  end

  // Range check per entry and serial scan for shared counters.
  always_comb begin
    used  = '0;
    clash = 1'b0;
    bad_o = '0;
    sel   = '0;
    for (int c = 0; c < N_CLI; c++) begin
      sel      = map_q[c*SEL_W +: SEL_W];
      bad_o[c] = (sel >= SEL_W'(N_CRD));
      if (wfq_i[c] && !bad_o[c]) begin
        if (used[sel]) clash = 1'b1;
        used[sel] = 1'b1;
      end
    end
  end

  assign map_o     = map_q;
  assign cfg_err_o = clash | (|(bad_o & wfq_i));
endmodule

// File: rtl/ets_credit_ctr.sv
module ets_credit_ctr #(
  parameter int AMT_W = 32,
  parameter int LEN_W = 16,
  parameter int CTR_W = AMT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refill_i,
  input  logic [AMT_W-1:0] weight_i,
  input  logic [AMT_W-1:0] bound_i,
  input  logic             debit_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             neg_o
);
  logic signed [CTR_W-1:0] cnt_q, cnt_d, sum, clip, wext, bext, lext;
  logic                    cnt_en;

  assign wext   = $signed({{(CTR_W-AMT_W){1'b0}}, weight_i});
  assign bext   = $signed({{(CTR_W-AMT_W){1'b0}}, bound_i});
  assign lext   = $signed({{(CTR_W-LEN_W){1'b0}}, len_i});
  assign cnt_en = refill_i | debit_i;

  // Add weight, limit to ceiling, then take the length away.
  always_comb begin
    sum   = refill_i ? (cnt_q + wext) : cnt_q;
    clip  = (refill_i && (sum > bext)) ? bext : sum;
    cnt_d = debit_i ? (clip - lext) : clip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign neg_o = cnt_q[CTR_W-1];
endmodule

// File: rtl/ets_credit_gate.sv
module ets_credit_gate #(
  parameter int N_CLI = 9,
  parameter int N_CRD = 9,
  parameter int SEL_W = 4,
  parameter int LEN_W = 16
) (
  input  logic [N_CLI-1:0]       req_i,
  input  logic [N_CLI-1:0]       wfq_i,
  input  logic [N_CLI*SEL_W-1:0] map_i,
  input  logic [N_CLI-1:0]       bad_i,
  input  logic [N_CRD-1:0]       neg_i,
  input  logic                   grant_vld_i,
  input  logic [SEL_W-1:0]       grant_id_i,
  output logic [N_CLI-1:0]       eligible_o,
  output logic                   refill_o,
  output logic [N_CRD-1:0]       debit_o
);
  localparam int SLOTS = 1 << SEL_W;

  logic [SLOTS-1:0]       neg_ext, wfq_ext, bad_ext;
  logic [SLOTS*SEL_W-1:0] map_ext;
  logic [N_CLI-1:0]       blocked, wfq_req;
  logic [SEL_W-1:0]       sel, gsel;
  logic                   hit;

  assign neg_ext = SLOTS'(neg_i);
  assign wfq_ext = SLOTS'(wfq_i);
  assign bad_ext = SLOTS'(bad_i);
  assign map_ext = (SLOTS*SEL_W)'(map_i);

  always_comb begin
    blocked = '0;
    sel     = '0;
    for (int c = 0; c < N_CLI; c++) begin
      sel = map_i[c*SEL_W +: SEL_W];
      if (wfq_i[c]) blocked[c] = bad_i[c] ? 1'b1 : neg_ext[sel];
    end
  end

  assign wfq_req    = req_i & wfq_i;
  assign eligible_o = req_i & ~blocked;
  assign refill_o   = (|wfq_req) && ((wfq_req & ~blocked) == '0);

  assign gsel = map_ext[grant_id_i*SEL_W +: SEL_W];
  assign hit  = grant_vld_i && (grant_id_i < SEL_W'(N_CLI))
              && wfq_ext[grant_id_i] && !bad_ext[grant_id_i];

  always_comb begin
    debit_o = '0;
    for (int k = 0; k < N_CRD; k++) debit_o[k] = hit && (gsel == SEL_W'(k));
  end
endmodule

// File: rtl/ets_credit_unit.sv
module ets_credit_unit
  import ets_credit_pkg::*;
#(
  parameter int N_CLI = NUM_CLIENTS,
  parameter int N_CRD = NUM_COUNTERS,
  parameter int SEL_W = SEL_BITS,
  parameter int AMT_W = AMT_BITS,
  parameter int LEN_W = LEN_BITS,
  parameter logic [N_CLI*SEL_W-1:0] MAP_INIT = MAP_DEFAULT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CLI-1:0]       req_i,
  input  logic [N_CLI-1:0]       wfq_i,
  input  logic                   map_wr_i,
  input  logic [N_CLI*SEL_W-1:0] map_wdata_i,
  input  logic [N_CRD*AMT_W-1:0] weight_i,
  input  logic [N_CRD*AMT_W-1:0] bound_i,
  input  logic                   grant_vld_i,
  input  logic [SEL_W-1:0]       grant_id_i,
  input  logic [LEN_W-1:0]       grant_len_i,
  output logic [N_CLI-1:0]       eligible_o,
  output logic [N_CLI*SEL_W-1:0] map_o,
  output logic                   cfg_err_o
);
  localparam int CTR_W = AMT_W + 2;

  logic [N_CLI-1:0] bad;
  logic [N_CRD-1:0] neg, debit;
  logic             refill_due;

  ets_credit_map #(.N_CLI(N_CLI), .N_CRD(N_CRD), .SEL_W(SEL_W), .MAP_INIT(MAP_INIT)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_i(map_wr_i), .wdata_i(map_wdata_i),
    .wfq_i(wfq_i), .map_o(map_o), .bad_o(bad), .cfg_err_o(cfg_err_o)
  );

  ets_credit_gate #(.N_CLI(N_CLI), .N_CRD(N_CRD), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_gate (
    .req_i(req_i), .wfq_i(wfq_i), .map_i(map_o), .bad_i(bad), .neg_i(neg),
    .grant_vld_i(grant_vld_i), .grant_id_i(grant_id_i),
    .eligible_o(eligible_o), .refill_o(refill_due), .debit_o(debit)
  );

  for (genvar k = 0; k < N_CRD; k++) begin : g_ctr
    ets_credit_ctr #(.AMT_W(AMT_W), .LEN_W(LEN_W), .CTR_W(CTR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .refill_i(refill_due),
      .weight_i(weight_i[k*AMT_W +: AMT_W]), .bound_i(bound_i[k*AMT_W +: AMT_W]),
      .debit_i(debit[k]), .len_i(grant_len_i), .neg_o(neg[k])
    );
  end
endmodule

// File: rtl/ets_credit_chk.sv
module ets_credit_chk #(
  parameter int N_CLI = 9,
  parameter int N_CRD = 9,
  parameter int SEL_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CLI-1:0]       req_i,
  input logic [N_CLI-1:0]       wfq_i,
  input logic                   map_wr_i,
  input logic [N_CLI*SEL_W-1:0] map_wdata_i,
  input logic [N_CLI-1:0]       eligible_o,
  input logic [N_CLI*SEL_W-1:0] map_o,
  input logic                   cfg_err_o,
  input logic                   refill_i
);
  AST_ELIG_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible_o & ~req_i) == '0); // R2
  AST_PLAIN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible_o & req_i & ~wfq_i) == (req_i & ~wfq_i)); // R2
  AST_MAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_i |=> (map_o == $past(map_wdata_i))); // R8
  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr_i |=> $stable(map_o)); // R8
  AST_REFILL_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    refill_i |-> (((req_i & wfq_i) != '0) && ((eligible_o & wfq_i) == '0))); // R7

  for (genvar c = 0; c < N_CLI; c++) begin : g_ent
    AST_BAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (wfq_i[c] && (map_o[c*SEL_W +: SEL_W] >= SEL_W'(N_CRD))) |-> (!eligible_o[c] && cfg_err_o)); // R10
  end
endmodule

bind ets_credit_unit ets_credit_chk #(.N_CLI(N_CLI), .N_CRD(N_CRD), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .wfq_i(wfq_i), .map_wr_i(map_wr_i),
  .map_wdata_i(map_wdata_i), .eligible_o(eligible_o), .map_o(map_o),
  .cfg_err_o(cfg_err_o), .refill_i(refill_due)
);

// File: tb/tb_ets_credit_unit.sv
module tb_ets_credit_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [8:0]    req, wfq, elig;
  logic          map_wr, gvld, cfg_err;
  logic [35:0]   map_wdata, map_q;
  logic [287:0]  weight, bound;
  logic [3:0]    gid;
  logic [15:0]   glen;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  // {req, wfq, grant_vld, grant_id, grant_len, expected eligible}
  localparam logic [47:0] TBL [NV] = '{
    {9'h018, 9'h018, 1'b0, 4'd0, 16'd0,   9'h018},
    {9'h018, 9'h018, 1'b1, 4'd3, 16'd50,  9'h018},
    {9'h018, 9'h018, 1'b0, 4'd0, 16'd0,   9'h010},
    {9'h018, 9'h018, 1'b1, 4'd4, 16'd30,  9'h010},
    {9'h018, 9'h018, 1'b0, 4'd0, 16'd0,   9'h000},
    {9'h018, 9'h018, 1'b0, 4'd0, 16'd0,   9'h018},
    {9'h019, 9'h018, 1'b1, 4'd0, 16'd500, 9'h019},
    {9'h019, 9'h019, 1'b1, 4'd9, 16'd999, 9'h019},
    {9'h019, 9'h019, 1'b1, 4'd0, 16'd100, 9'h019},
    {9'h019, 9'h019, 1'b1, 4'd3, 16'd51,  9'h019},
    {9'h019, 9'h019, 1'b0, 4'd0, 16'd0,   9'h011}
  };

  ets_credit_unit dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wfq_i(wfq), .map_wr_i(map_wr),
    .map_wdata_i(map_wdata), .weight_i(weight), .bound_i(bound),
    .grant_vld_i(gvld), .grant_id_i(gid), .grant_len_i(glen),
    .eligible_o(elig), .map_o(map_q), .cfg_err_o(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; wfq = '0; map_wr = 1'b0; map_wdata = '0;
    gvld = 1'b0; gid = '0; glen = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input logic [8:0] r, input logic [8:0] w, input logic v,
                     input logic [3:0] id, input logic [15:0] len);
    @(negedge clk);
    req = r; wfq = w; gvld = v; gid = id; glen = len;
    #1;
  endtask

  initial begin
    for (int k = 0; k < 9; k++) begin
      weight[k*32 +: 32] = 32'd100;
      bound[k*32 +: 32]  = 32'd250;
    end
    do_reset();

    // R1: reset state at the ports
    cyc(9'h1FF, 9'h1FF, 1'b0, 4'd0, 16'd0);
    chk("R1 map", 36'(map_q), 36'h543210876);
    chk("R1 cfg", 36'(cfg_err), 36'd0);
    chk("R1 elig", 36'(elig), 36'h1FF);
    do_reset();

    // Table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i][47:39], TBL[i][38:30], TBL[i][29], TBL[i][28:25], TBL[i][24:9]);
      chk($sformatf("R3/R4/R5/R7 vector %0d", i), 36'(elig), 36'(TBL[i][8:0]));
    end

    // R6 and R11: counter 0 (client 3) weight 150, ceiling 100
    weight[31:0] = 32'd150;
    bound[31:0]  = 32'd100;
    do_reset();
    cyc(9'h008, 9'h008, 1'b1, 4'd3, 16'd1);
    chk("R3 zero not blocking", 36'(elig), 36'h008);
    cyc(9'h008, 9'h008, 1'b0, 4'd0, 16'd0);
    chk("R3 negative blocks", 36'(elig), 36'h000);
    cyc(9'h008, 9'h008, 1'b1, 4'd3, 16'd101);
    chk("R5 refill restores", 36'(elig), 36'h008);
    cyc(9'h008, 9'h008, 1'b0, 4'd0, 16'd0);
    chk("R6 ceiling applied", 36'(elig), 36'h000);
    cyc(9'h008, 9'h008, 1'b1, 4'd3, 16'd101);
    chk("R6 refill to ceiling", 36'(elig), 36'h008);
    cyc(9'h008, 9'h008, 1'b1, 4'd3, 16'd10);
    chk("R11 blocked before joint", 36'(elig), 36'h000);
    cyc(9'h008, 9'h008, 1'b1, 4'd3, 16'd91);
    chk("R11 after joint", 36'(elig), 36'h008);
    cyc(9'h008, 9'h008, 1'b0, 4'd0, 16'd0);
    chk("R11 order add-clip-subtract", 36'(elig), 36'h000);

    // R8 R9 R10 R2: map handling
    do_reset();
    cyc(9'h1FF, 9'h018, 1'b0, 4'd0, 16'd0);
    map_wr = 1'b1; map_wdata = 36'h543200876;
    #1 chk("R8 no early load", 36'(map_q), 36'h543210876);
    cyc(9'h1FF, 9'h018, 1'b0, 4'd0, 16'd0);
    map_wr = 1'b0;
    #1 chk("R8 load", 36'(map_q), 36'h543200876);
    chk("R9 shared counter", 36'(cfg_err), 36'd1);
    cyc(9'h1FF, 9'h008, 1'b0, 4'd0, 16'd0);
    chk("R2 non-weighted share ignored", 36'(cfg_err), 36'd0);
    map_wr = 1'b1; map_wdata = 36'h543219876;
    cyc(9'h1FF, 9'h008, 1'b0, 4'd0, 16'd0);
    map_wr = 1'b0;
    #1 chk("R10 range error", 36'(cfg_err), 36'd1);
    chk("R10 out of range blocks", 36'(elig), 36'h1F7);
    cyc(9'h1FF, 9'h000, 1'b0, 4'd0, 16'd0);
    chk("R2 bad entry ignored cfg", 36'(cfg_err), 36'd0);
    chk("R2 bad entry ignored elig", 36'(elig), 36'h1FF);
    cyc(9'h1FF, 9'h000, 1'b0, 4'd0, 16'd0);
    chk("R8 hold", 36'(map_q), 36'h543219876);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule